// File: doc/BRIEF.md
# Interleaved Memory Decoder Lookup

This block is a bank of host-programmed address decoders that turns a 64-bit host physical address into an 8-bit downstream port number. Software fills in each decoder through a simple write port. A decoder holds a base, a size, an interleave granularity code, an interleave ways code, a committed flag and a list of eight target port numbers. Ranges are aligned to 256 MiB, so only the upper nibble of each low address word is kept.

For each lookup request the block scans the decoders in ascending index order. The first decoder whose range holds the address decides the answer. If that decoder is not committed, or its ways code is out of range, the lookup misses, even when a later decoder would also match. Otherwise the address is divided by the granularity and reduced modulo the number of ways. This gives a slot in the target list, and the byte in that slot is returned as the port. The answer appears one clock after the request.

Top module: `hdm_lookup_bank`

## Requirements
- R1: After reset `rsp_valid` is low, and every decoder is empty (zero size), so every lookup misses until software programs a decoder.
- R2: `rsp_valid` is high in exactly the cycle after each cycle in which `req_valid` is high. `rsp_hit` and `rsp_port` in that cycle belong to that request.
- R3: A decoder's base is {base_hi[31:0], base_lo[31:28]} times 256 MiB, and its size is formed the same way from size_hi and size_lo. Bits 27:0 of both low words are ignored. The decoder matches when base <= address < base + size, where the sum is taken without wrap-around.
- R4: When more than one decoder matches, the lowest index decides the result.
- R5: If the deciding decoder has its committed bit clear, the lookup misses, and no later decoder is consulted.
- R6: Control word layout: bits 3:0 are the granularity code g, bits 7:4 are the ways code w, and bit 8 is the committed flag. The slot is (address >> (8+g)) mod 2^w.
- R7: Slots 0..3 come from target word low bits [8k+7:8k]. Slots 4..7 come from target word high bits [8(k-4)+7:8(k-4)].
- R8: A deciding decoder whose ways code is above 3 produces a miss.
- R9: Only decoders with index below NUM_DEC exist. Writes that address a higher index have no effect, and such decoders never match.
- R10: A miss returns `rsp_port` = 0. `rsp_hit` is never high without `rsp_valid`.
- R11: Field selector codes: 0 base low, 1 base high, 2 size low, 3 size high, 4 control, 5 target low, 6 target high. Code 7 is ignored. A write is seen by lookups issued in a later cycle; a lookup in the same cycle still sees the old setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_dec | input | 2 | Decoder index being written |
| cfg_field | input | 3 | Field selector (R11 codes) |
| cfg_wdata | input | 32 | Write data |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | 64 | Host physical address to look up |
| rsp_valid | output | 1 | Lookup result valid, one cycle after the request |
| rsp_hit | output | 1 | Address resolved to a port |
| rsp_port | output | 8 | Selected downstream port number, 0 on miss |

## Verification
The bench builds the block with NUM_DEC = 3. With that setting the two-bit write index can address a decoder slot that does not exist, so the rule that writes to index 3 are dropped and never produce a match becomes testable. Three decoders are also enough to build overlapping ranges, first-match priority and the no-fall-through miss. All ways codes 0 to 4 are used with granularity codes 0 to 3 and 7, and a range ending exactly at the top of the 64-bit space checks the non-wrapping end compare.

// File: rtl/hdm_lookup_pkg.sv
package hdm_lookup_pkg;
   localparam int ADDR_W    = 64;
   localparam int WORD_W    = 32;
   localparam int PORT_W    = 8;
   localparam int BLK_SHIFT = 28;                       // 256 MiB units
   localparam int BLK_W     = ADDR_W - BLK_SHIFT;       // block number width
   localparam int LO_KEEP   = WORD_W - BLK_SHIFT;       // kept low-word bits
   localparam int GRAN_W    = 4;
   localparam int WAYS_W    = 4;
   localparam int SLOTS     = 8;
   localparam int SLOT_W    = $clog2(SLOTS);
   localparam int MAX_DEC   = 4;
   localparam int IDX_W     = $clog2(MAX_DEC);
   localparam int GRAN_BASE = 8;                        // code 0 = 256 bytes

   typedef enum logic [2:0] {
      FLD_BASE_LO = 3'd0,
      FLD_BASE_HI = 3'd1,
      FLD_SIZE_LO = 3'd2,
      FLD_SIZE_HI = 3'd3,
      FLD_CTRL    = 3'd4,
      FLD_TGT_LO  = 3'd5,
      FLD_TGT_HI  = 3'd6,
      FLD_NONE    = 3'd7
   } fld_e;

   typedef struct packed {
      logic [BLK_W-1:0]        base_blk;
      logic [BLK_W-1:0]        size_blk;
      logic [GRAN_W-1:0]       gran;
      logic [WAYS_W-1:0]       ways;
      logic                    commit;
      logic [SLOTS*PORT_W-1:0] tgts;
   } dec_cfg_t;
endpackage

// File: rtl/hdm_decoder_regs.sv
module hdm_decoder_regs
   import hdm_lookup_pkg::*;
#(
   parameter int NUM_DEC = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      we,
   input  logic [IDX_W-1:0]          dec,
   input  logic [2:0]                field,
   input  logic [WORD_W-1:0]         wdata,
   output dec_cfg_t [MAX_DEC-1:0]    cfg_o
);
   localparam int HALF = SLOTS * PORT_W / 2;

   for (genvar i = 0; i < MAX_DEC; i++) begin : g_dec
      if (i < NUM_DEC) begin : g_real
         dec_cfg_t r;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               r <= '0;
            end else if (we && dec == IDX_W'(i)) begin
               case (fld_e'(field))
                  FLD_BASE_LO: r.base_blk[LO_KEEP-1:0]     <= wdata[WORD_W-1:BLK_SHIFT];
                  FLD_BASE_HI: r.base_blk[BLK_W-1:LO_KEEP] <= wdata;
                  FLD_SIZE_LO: r.size_blk[LO_KEEP-1:0]     <= wdata[WORD_W-1:BLK_SHIFT];
                  FLD_SIZE_HI: r.size_blk[BLK_W-1:LO_KEEP] <= wdata;
                  FLD_CTRL: begin
                     r.gran   <= wdata[GRAN_W-1:0];
                     r.ways   <= wdata[GRAN_W+WAYS_W-1:GRAN_W];
                     r.commit <= wdata[GRAN_W+WAYS_W];
                  end
                  FLD_TGT_LO:  r.tgts[HALF-1:0]       <= wdata;
                  FLD_TGT_HI:  r.tgts[2*HALF-1:HALF]  <= wdata;
                  default: ;
               endcase
            end
         end
         assign cfg_o[i] = r;
      end else begin : g_absent
         assign cfg_o[i] = '0;
      end
   end
endmodule

// File: rtl/hdm_range_match.sv
module hdm_range_match
   import hdm_lookup_pkg::*;
(
   input  logic [BLK_W-1:0] addr_blk,
   input  logic [BLK_W-1:0] base_blk,
   input  logic [BLK_W-1:0] size_blk,
   output logic             match
);
   logic [BLK_W:0] end_blk;
   always_comb begin
      end_blk = {1'b0, base_blk} + {1'b0, size_blk};
      match   = (addr_blk >= base_blk) && ({1'b0, addr_blk} < end_blk);
   end
endmodule

// File: rtl/hdm_target_pick.sv
module hdm_target_pick
   import hdm_lookup_pkg::*;
(
   input  logic [ADDR_W-1:0]       addr,
   input  logic [GRAN_W-1:0]       gran,
   input  logic [WAYS_W-1:0]       ways,
   input  logic [SLOTS*PORT_W-1:0] tgts,
   output logic                    ways_ok,
   output logic [PORT_W-1:0]       port
);
   logic [ADDR_W-1:0] chunk;
   logic [SLOT_W-1:0] mask;
   logic [SLOT_W-1:0] slot;

   always_comb begin
      ways_ok = (ways <= WAYS_W'(SLOT_W));
      chunk   = addr >> (GRAN_BASE + int'(gran));
      mask    = '0;
      for (int b = 0; b < SLOT_W; b++) begin
         if (WAYS_W'(b) < ways) mask[b] = 1'b1;
      end
      slot = chunk[SLOT_W-1:0] & mask;
      port = tgts[slot*PORT_W +: PORT_W];
   end
endmodule

// File: rtl/hdm_lookup_bank.sv
module hdm_lookup_bank
   import hdm_lookup_pkg::*;
#(
   parameter int NUM_DEC = 4
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cfg_we,
   input  logic [1:0]  cfg_dec,
   input  logic [2:0]  cfg_field,
   input  logic [31:0] cfg_wdata,
   input  logic        req_valid,
   input  logic [63:0] req_addr,
   output logic        rsp_valid,
   output logic        rsp_hit,
   output logic [7:0]  rsp_port
);
   if (NUM_DEC < 1 || NUM_DEC > MAX_DEC) begin : g_bad_num_dec
      $error("hdm_lookup_bank: NUM_DEC must lie in 1..%0d", MAX_DEC);
   end

   dec_cfg_t [MAX_DEC-1:0] cfg;
   logic     [MAX_DEC-1:0] match_vec;
   dec_cfg_t               sel_cfg;
   logic                   found;
   logic                   ways_ok;
   logic [PORT_W-1:0]      pick_port;
   logic                   hit_c;

   hdm_decoder_regs #(.NUM_DEC(NUM_DEC)) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .dec   (cfg_dec),
      .field (cfg_field),
      .wdata (cfg_wdata),
      .cfg_o (cfg)
   );

   for (genvar i = 0; i < MAX_DEC; i++) begin : g_match
      hdm_range_match u_match (
         .addr_blk (req_addr[ADDR_W-1:BLK_SHIFT]),
         .base_blk (cfg[i].base_blk),
         .size_blk (cfg[i].size_blk),
         .match    (match_vec[i])
      );
   end

   // lowest matching index decides; a later match never overrides it
   always_comb begin
      found   = 1'b0;
      sel_cfg = '0;
      for (int i = MAX_DEC - 1; i >= 0; i--) begin
         if (match_vec[i]) begin
            found   = 1'b1;
            sel_cfg = cfg[i];
         end
      end
   end

   hdm_target_pick u_pick (
      .addr    (req_addr),
      .gran    (sel_cfg.gran),
      .ways    (sel_cfg.ways),
      .tgts    (sel_cfg.tgts),
      .ways_ok (ways_ok),
      .port    (pick_port)
   );

   assign hit_c = found && sel_cfg.commit && ways_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_port  <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_hit   <= req_valid && hit_c;
         rsp_port  <= (req_valid && hit_c) ? pick_port : '0;
      end
   end

   p_req_gives_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   p_idle_gives_none_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   p_hit_needs_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_hit |-> rsp_valid);
   p_miss_port_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_hit) |-> (rsp_port == '0));

   for (genvar i = 0; i < MAX_DEC; i++) begin : g_chk
      p_match_nonempty_r3: assert property (@(posedge clk) disable iff (!rst_n)
         match_vec[i] |-> (cfg[i].size_blk != '0));
      if (i >= NUM_DEC) begin : g_absent_chk
         p_absent_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !match_vec[i]);
      end
   end
endmodule

// File: tb/hdm_lookup_bank_bench.sv
`timescale 1ns/1ps
module hdm_lookup_bank_bench;
   localparam int NDEC = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_dec = '0;
   logic [2:0]  cfg_field = '0;
   logic [31:0] cfg_wdata = '0;
   logic        req_valid = 1'b0;
   logic [63:0] req_addr = '0;
   logic        rsp_valid, rsp_hit;
   logic [7:0]  rsp_port;

   int total = 0;
   int bad = 0;
   int cycles = 0;
   string tag = "R1";
   bit mon_en = 1'b0;

   always #4 clk = ~clk;

   hdm_lookup_bank #(.NUM_DEC(NDEC)) u_hdm_lookup_bank (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_dec(cfg_dec),
      .cfg_field(cfg_field), .cfg_wdata(cfg_wdata), .req_valid(req_valid),
      .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
      .rsp_port(rsp_port));

   // reference state, one word per field as software wrote it
   logic [31:0] m_blo[4], m_bhi[4], m_slo[4], m_shi[4], m_ctl[4], m_tlo[4], m_thi[4];
   logic       exp_v = 1'b0, exp_h = 1'b0;
   logic [7:0] exp_p = '0;

   function automatic void ref_lookup(input logic [63:0] a, output logic h, output logic [7:0] p);
      h = 1'b0;
      p = 8'h00;
      for (int i = 0; i < NDEC; i++) begin
         logic [64:0] b, s;
         int g, w, slot;
         b = {1'b0, m_bhi[i], m_blo[i][31:28], 28'h0};
         s = {1'b0, m_shi[i], m_slo[i][31:28], 28'h0};
         if ({1'b0, a} >= b && {1'b0, a} < b + s) begin
            g = int'(m_ctl[i][3:0]);
            w = int'(m_ctl[i][7:4]);
            if (m_ctl[i][8] && w <= 3) begin
               slot = int'((a / (64'd256 << g)) % (64'd1 << w));
               h = 1'b1;
               p = (slot < 4) ? m_tlo[i][slot*8 +: 8] : m_thi[i][(slot-4)*8 +: 8];
            end
            return;
         end
      end
   endfunction

   always @(posedge clk) begin
      logic h;
      logic [7:0] p;
      if (!rst_n) begin
         exp_v = 1'b0; exp_h = 1'b0; exp_p = '0;
         for (int i = 0; i < 4; i++) begin
            m_blo[i] = '0; m_bhi[i] = '0; m_slo[i] = '0; m_shi[i] = '0;
            m_ctl[i] = '0; m_tlo[i] = '0; m_thi[i] = '0;
         end
      end else begin
         ref_lookup(req_addr, h, p);
         exp_v = req_valid;
         exp_h = req_valid && h;
         exp_p = (req_valid && h) ? p : 8'h00;
         if (cfg_we && int'(cfg_dec) < NDEC) begin
            case (cfg_field)
               3'd0: m_blo[cfg_dec] = cfg_wdata;
               3'd1: m_bhi[cfg_dec] = cfg_wdata;
               3'd2: m_slo[cfg_dec] = cfg_wdata;
               3'd3: m_shi[cfg_dec] = cfg_wdata;
               3'd4: m_ctl[cfg_dec] = cfg_wdata;
               3'd5: m_tlo[cfg_dec] = cfg_wdata;
               3'd6: m_thi[cfg_dec] = cfg_wdata;
               default: ;
            endcase
         end
      end
   end

   // compared every clock, away from the active edge
   always @(negedge clk) begin
      cycles++;
      if (mon_en) begin
         total++;
         if (rsp_valid !== exp_v || rsp_hit !== exp_h || rsp_port !== exp_p) begin
            bad++;
            $display("FAIL %s: valid/hit/port actual=%0b/%0b/%02h expected=%0b/%0b/%02h",
                     tag, rsp_valid, rsp_hit, rsp_port, exp_v, exp_h, exp_p);
         end
      end
   end

   task automatic idle();
      @(negedge clk);
      cfg_we = 1'b0; req_valid = 1'b0;
   endtask

   task automatic wr(input int d, input int f, input logic [31:0] v);
      @(negedge clk);
      req_valid = 1'b0;
      cfg_we = 1'b1; cfg_dec = 2'(d); cfg_field = 3'(f); cfg_wdata = v;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic look(input logic [63:0] a);
      @(negedge clk);
      cfg_we = 1'b0;
      req_valid = 1'b1; req_addr = a;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic prog(input int d, input logic [31:0] bhi, input logic [31:0] blo,
                       input logic [31:0] shi, input logic [31:0] slo,
                       input logic [31:0] ctl, input logic [31:0] tlo, input logic [31:0] thi);
      wr(d, 0, blo); wr(d, 1, bhi); wr(d, 2, slo); wr(d, 3, shi);
      wr(d, 4, ctl); wr(d, 5, tlo); wr(d, 6, thi);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      tag = "R1";
      total++;
      if (rsp_valid !== 1'b0) begin
         bad++;
         $display("FAIL R1: rsp_valid in reset actual=%0b expected=0", rsp_valid);
      end
      rst_n = 1'b1;
      mon_en = 1'b1;
      look(64'h0); look(64'h1_0000_0000); idle();

      // R3 / R11: range edges, low-word bits 27:0 ignored
      tag = "R3";
      prog(0, 32'h1, 32'h0FFF_FFFF, 32'h0, 32'h2000_0123, 32'h100, 32'h4433_2211, 32'h8877_6655);
      look(64'h0_FFFF_FFFF); look(64'h1_0000_0000); look(64'h1_1FFF_FFFF);
      look(64'h1_2000_0000);

      // R6 / R7: ways 8, granularity 1 KiB, walk every slot and wrap
      tag = "R7";
      prog(1, 32'h2, 32'h0, 32'h0, 32'h1000_0000, 32'h132, 32'hA3A2_A1A0, 32'hA7A6_A5A4);
      for (int k = 0; k < 10; k++) look(64'h2_0000_0000 + 64'(k) * 1024);
      tag = "R6";
      for (int w = 0; w < 3; w++) begin
         wr(1, 4, 32'h100 | 32'(w << 4) | 32'(w + 1));
         for (int k = 0; k < 9; k++) look(64'h2_0000_0000 + 64'(k) * (64'd256 << (w + 1)) + 64'd7);
      end
      wr(1, 4, 32'h137);
      for (int k = 0; k < 9; k++) look(64'h2_0000_0000 + 64'(k) * 32768);

      // R4: decoder 2 overlaps decoder 1, lower index wins
      tag = "R4";
      prog(2, 32'h2, 32'h0, 32'h0, 32'h3000_0000, 32'h100, 32'hEEEE_EEEE, 32'hEEEE_EEEE);
      look(64'h2_0000_0400); look(64'h2_1000_0000); look(64'h2_2FFF_FFFF);

      // R5: uncommitted first match does not fall through
      tag = "R5";
      wr(1, 4, 32'h032);
      look(64'h2_0000_0000); look(64'h2_0FFF_FF00); look(64'h2_1000_0000);

      // R8: ways code 4 and above
      tag = "R8";
      wr(0, 4, 32'h140); look(64'h1_0000_0000);
      wr(0, 4, 32'h1F0); look(64'h1_1000_0000);

      // R9: writes to the absent decoder 3 are dropped
      tag = "R9";
      prog(3, 32'h5, 32'h0, 32'h1, 32'h0, 32'h100, 32'h5555_5555, 32'h5555_5555);
      look(64'h5_0000_0000); look(64'h5_8000_0000);
      // R11: field code 7 ignored; same-cycle write seen only later
      tag = "R11";
      wr(0, 7, 32'hFFFF_FFFF); look(64'h1_0000_0000);
      @(negedge clk);
      cfg_we = 1'b1; cfg_dec = 2'd0; cfg_field = 3'd4; cfg_wdata = 32'h100;
      req_valid = 1'b1; req_addr = 64'h1_0000_0000;
      @(negedge clk);
      cfg_we = 1'b0;
      @(negedge clk);
      req_valid = 1'b0;
      idle();

      // R3: range ending at the very top of the address space
      tag = "R3";
      prog(0, 32'hFFFF_FFFF, 32'hF000_0000, 32'h0, 32'h1000_0000, 32'h100, 32'h0000_0099, 32'h0);
      look(64'hFFFF_FFFF_FFFF_FFFF); look(64'hFFFF_FFFF_F000_0000); look(64'hFFFF_FFFF_EFFF_FFFF);

      // R10: back-to-back mixed traffic
      tag = "R10";
      @(negedge clk);
      for (int k = 0; k < 40; k++) begin
         req_valid = (k % 3) != 2;
         req_addr = {$urandom, $urandom} & 64'hFFFF_FFFF_3FFF_FFFF;
         if (k % 4 == 0) req_addr = 64'h2_0000_0000 + 64'($urandom_range(0, 32'h2FFF_FFFF));
         @(negedge clk);
      end
      req_valid = 1'b0;
      idle(); idle();
      mon_en = 1'b0;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      wait (cycles > 20000);
      bad++;
      $display("FAIL watchdog: actual=%0d cycles expected=done", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule